// File: doc/BRIEF.md
# Dual-Mode Transform Row Input Buffer

This block feeds an N×N systolic transform array with block samples. For a forward transform these are prediction residues; for an inverse transform they are coefficients. It holds N small FIFOs, one per array row, each N entries deep. Column position j of every block row that is loaded goes into FIFO j. Each FIFO therefore holds one column position across successive block rows. Loading runs at the same time as issue, so memory fetches overlap with array computation.

Two load patterns can be chosen at run time. In parallel mode one accepted beat carries a whole block row, with all N samples side by side on the data bus. In sequential mode the samples of a row arrive in lane 0 over N accepted beats, in column order. The block switches between the two patterns only when it is idle, so a row that is partly loaded is never split across modes.

When every FIFO holds at least one entry and the array asks for data, the block pops one entry from each FIFO. It sends them to the array's left column as a diagonal wavefront: array row r receives its sample r cycles after array row 0.

Top module: `row_feed_buffer`

## Requirements
- R1: While reset is high and in the first cycle after it, every bit of `arr_valid_o` is 0. After reset all FIFOs are empty and `ld_ready_o` is 1.
- R2: When `mode_i`=0 (parallel) takes effect, an accepted beat writes bits [j*W +: W] of `ld_data_i` into FIFO j, for every j at once.
- R3: When `mode_i`=1 (sequential) takes effect, the k-th accepted beat of a row (k counted from 0 and wrapping after N) writes lane 0, bits [W-1:0], into FIFO k. The other lanes are ignored.
- R4: If `issue_en_i` is 1 and no FIFO is empty at a clock edge, one entry is popped from every FIFO, and `arr_valid_o[0]` is 1 in the next cycle with FIFO 0's oldest entry.
- R5: Array row r shows its sample exactly r cycles after array row 0 for the same wavefront. Its data, `arr_data_o[r*W +: W]`, is the entry popped from FIFO r.
- R6: No wavefront starts while `issue_en_i` is 0 or any FIFO is empty.
- R7: `ld_ready_o` is 0 when a target FIFO is full: any FIFO in parallel mode, or the FIFO at the current column in sequential mode. A beat offered while `ld_ready_o` is 0 is dropped and never reaches the array.
- R8: `mode_i` is taken in only while all FIFOs are empty. A change of `mode_i` in the middle of a sequential row does not affect how the rest of that row is loaded.
- R9: Each FIFO keeps first-in first-out order. It holds exactly N entries before refusing more.
- R10: In parallel mode, with `issue_en_i` held at 1, the block accepts one row per cycle with `ld_ready_o` staying at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Load pattern: 0 = whole row per beat, 1 = one sample per beat |
| ld_valid_i | input | 1 | Load beat present |
| ld_data_i | input | N*W | Load beat samples, lane j in bits [j*W +: W] |
| ld_ready_o | output | 1 | Buffer can take the offered beat |
| issue_en_i | input | 1 | Array can take a new wavefront |
| arr_valid_o | output | N | Per array row sample strobe |
| arr_data_o | output | N*W | Per array row sample, row r in bits [r*W +: W] |

## Verification
A corrupted column pointer or a wrong write-enable shows up on the data output as a sample in the wrong array row. This appears as soon as the wavefront that holds it leaves the skew lines, at most N cycles after issue. A wrong occupancy count shows up in two ways at the ports. It can appear as an early or missing wavefront. It can also appear as `ld_ready_o` dropping too soon or too late, which then lets an extra sample through or loses one before the buffer drains. A faulty delay line breaks the fixed r-cycle gap between rows within one wavefront. Mode handling errors appear on the next lane-0-only beat as a sample in the wrong row.

// File: rtl/row_feed_buffer_pkg.sv
package row_feed_buffer_pkg;

    typedef enum logic {
        LOAD_ROW  = 1'b0,
        LOAD_WORD = 1'b1
    } load_mode_e;

    localparam int unsigned DEF_SAMPLE_W = 16;
    localparam int unsigned DEF_DIM      = 4;

    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/row_fifo.sv
module row_fifo
    import row_feed_buffer_pkg::*;
#(
    parameter int unsigned W     = DEF_SAMPLE_W,
    parameter int unsigned DEPTH = DEF_DIM
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int unsigned AW = idx_w(DEPTH);
    localparam int unsigned CW = idx_w(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign head  = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push && !full) begin
                mem[wp] <= din;
                wp      <= bump(wp);
            end
            if (pop && !empty) begin
                rp <= bump(rp);
            end
            case ({push && !full, pop && !empty})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/load_ctrl.sv
module load_ctrl
    import row_feed_buffer_pkg::*;
#(
    parameter int unsigned N = DEF_DIM
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_i,
    input  logic         ld_valid_i,
    input  logic [N-1:0] fifo_full,
    input  logic [N-1:0] fifo_empty,
    output logic         ld_ready_o,
    output logic [N-1:0] wr_en,
    output load_mode_e   mode_eff
);
    localparam int unsigned PW = idx_w(N);

    load_mode_e    mode_q;
    logic [PW-1:0] col_q;
    logic          idle, accept;

    assign idle     = (&fifo_empty) && (col_q == '0);
    assign mode_eff = idle ? load_mode_e'(mode_i) : mode_q;

    always_comb begin
        if (mode_eff == LOAD_WORD) ld_ready_o = !fifo_full[col_q];
        else                       ld_ready_o = !(|fifo_full);
    end

    assign accept = ld_valid_i && ld_ready_o;

    always_comb begin
        wr_en = '0;
        if (accept) begin
            if (mode_eff == LOAD_WORD) wr_en[col_q] = 1'b1;
            else                       wr_en = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= LOAD_ROW;
            col_q  <= '0;
        end else begin
            mode_q <= mode_eff;
            if (accept && mode_eff == LOAD_WORD) begin
                col_q <= (col_q == PW'(N - 1)) ? '0 : col_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/skew_line.sv
module skew_line
    import row_feed_buffer_pkg::*;
#(
    parameter int unsigned W   = DEF_SAMPLE_W,
    parameter int unsigned LAT = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [W-1:0] in_dat,
    output logic         out_vld,
    output logic [W-1:0] out_dat
);
    logic [LAT-1:0] vld;
    logic [W-1:0]   dat [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else begin
            vld[0] <= in_vld;
            for (int k = 1; k < LAT; k++) vld[k] <= vld[k-1];
        end
        dat[0] <= in_dat;
        for (int k = 1; k < LAT; k++) dat[k] <= dat[k-1];
    end

    assign out_vld = vld[LAT-1];
    assign out_dat = dat[LAT-1];
endmodule

// File: rtl/row_feed_buffer.sv
module row_feed_buffer
    import row_feed_buffer_pkg::*;
#(
    parameter int unsigned N = DEF_DIM,
    parameter int unsigned W = DEF_SAMPLE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mode_i,
    input  logic           ld_valid_i,
    input  logic [N*W-1:0] ld_data_i,
    output logic           ld_ready_o,
    input  logic           issue_en_i,
    output logic [N-1:0]   arr_valid_o,
    output logic [N*W-1:0] arr_data_o
);
    logic [N-1:0] fifo_empty, fifo_full, wr_en;
    logic [W-1:0] head [N];
    logic         issue;
    load_mode_e   mode_eff;

    load_ctrl #(.N(N)) u_ctrl (
        .clk(clk), .rst(rst), .mode_i(mode_i), .ld_valid_i(ld_valid_i),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .ld_ready_o(ld_ready_o), .wr_en(wr_en), .mode_eff(mode_eff)
    );

    assign issue = issue_en_i && !(|fifo_empty);

    for (genvar r = 0; r < N; r++) begin : g_row
        logic [W-1:0] din;
        assign din = (mode_eff == LOAD_WORD) ? ld_data_i[W-1:0] : ld_data_i[r*W +: W];

        row_fifo #(.W(W), .DEPTH(N)) u_fifo (
            .clk(clk), .rst(rst), .push(wr_en[r]), .din(din), .pop(issue),
            .head(head[r]), .empty(fifo_empty[r]), .full(fifo_full[r])
        );

        skew_line #(.W(W), .LAT(r + 1)) u_skew (
            .clk(clk), .rst(rst), .in_vld(issue), .in_dat(head[r]),
            .out_vld(arr_valid_o[r]), .out_dat(arr_data_o[r*W +: W])
        );
    end
endmodule

// File: rtl/row_feed_buffer_chk.sv
module row_feed_buffer_chk
    import row_feed_buffer_pkg::*;
#(
    parameter int unsigned N = DEF_DIM
) (
    input logic         clk,
    input logic         rst,
    input logic         issue_en_i,
    input logic         ld_ready_o,
    input logic [N-1:0] arr_valid_o,
    input logic [N-1:0] fifo_empty,
    input logic [N-1:0] fifo_full,
    input load_mode_e   mode_eff
);
    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (arr_valid_o == '0));

    p_issue_starts_r4: assert property (@(posedge clk) disable iff (rst)
        (issue_en_i && !(|fifo_empty)) |=> arr_valid_o[0]);

    p_no_issue_r6: assert property (@(posedge clk) disable iff (rst)
        !(issue_en_i && !(|fifo_empty)) |=> !arr_valid_o[0]);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        ((|fifo_full) && mode_eff == LOAD_ROW) |-> !ld_ready_o);

    p_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(&fifo_empty) ##1 !(&fifo_empty) |-> $stable(mode_eff));

    for (genvar r = 1; r < N; r++) begin : g_skew
        p_skew_r5: assert property (@(posedge clk) disable iff (rst)
            arr_valid_o[r] == $past(arr_valid_o[r-1]));
    end
endmodule

bind row_feed_buffer row_feed_buffer_chk #(.N(N)) u_chk (
    .clk(clk), .rst(rst), .issue_en_i(issue_en_i), .ld_ready_o(ld_ready_o),
    .arr_valid_o(arr_valid_o), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .mode_eff(mode_eff)
);

// File: tb/row_feed_buffer_tb_top.sv
module row_feed_buffer_tb_top;
    localparam int N = 4;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           mode_i = 1'b0;
    logic           ld_valid_i = 1'b0;
    logic [N*W-1:0] ld_data_i = '0;
    logic           ld_ready_o;
    logic           issue_en_i = 1'b0;
    logic [N-1:0]   arr_valid_o;
    logic [N*W-1:0] arr_data_o;

    always #2 clk = ~clk;

    row_feed_buffer #(.N(N), .W(W)) dut_i (.*);

    logic [W-1:0] expq [N][$];
    int           skq  [N][$];
    int checks = 0, fails = 0, cyc = 0, seq_col = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: called at negedge; holds beat until accepted, leaves valid high
    task automatic send(input logic [N*W-1:0] d, input bit seq, input bit chk_rdy);
        ld_valid_i = 1'b1;
        ld_data_i  = d;
        #0.1;
        if (chk_rdy) check(ld_ready_o == 1'b1, "R10 ready sustained", ld_ready_o, 1);
        while (!ld_ready_o) begin @(negedge clk); #0.1; end
        if (seq) begin
            expq[seq_col].push_back(d[W-1:0]);
            seq_col = (seq_col + 1) % N;
        end else begin
            for (int r = 0; r < N; r++) expq[r].push_back(d[r*W +: W]);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        ld_valid_i = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [N*W-1:0] mk_row(input int k);
        logic [N*W-1:0] v;
        for (int j = 0; j < N; j++) v[j*W +: W] = W'(16'hA000 + k * 16 + j);
        return v;
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            cyc++;
            for (int r = 0; r < N; r++) begin
                if (arr_valid_o[r]) begin
                    if (expq[r].size() == 0) begin
                        check(0, "R7/R9 unexpected sample", arr_data_o[r*W +: W], 0);
                    end else begin
                        logic [W-1:0] e;
                        e = expq[r].pop_front();
                        check(arr_data_o[r*W +: W] == e, "R2/R3/R5 row data", arr_data_o[r*W +: W], e);
                    end
                    if (r == 0) begin
                        for (int q = 1; q < N; q++) skq[q].push_back(cyc);
                    end else if (skq[r].size() == 0) begin
                        check(0, "R5 skew orphan", r, 0);
                    end else begin
                        int c0;
                        c0 = skq[r].pop_front();
                        check(cyc - c0 == r, "R5 skew", cyc - c0, r);
                    end
                end
            end
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000 && !done) begin
            check(0, "watchdog", wd, 20000);
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check(arr_valid_o == '0, "R1 valid in reset", arr_valid_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(arr_valid_o == '0, "R1 valid after reset", arr_valid_o, 0);
        check(ld_ready_o == 1'b1, "R1 ready after reset", ld_ready_o, 1);

        // R2 R4 R10: parallel rows back to back with issue enabled
        issue_en_i = 1'b1;
        for (int k = 0; k < 6; k++) send(mk_row(k), 0, 1);
        idle(2 * N + 2);

        // R3: sequential rows; other lanes carry junk
        mode_i = 1'b1;
        for (int k = 0; k < 2 * N; k++) send({{(N-1){16'hDEAD}}, W'(16'h5000 + k)}, 1, 0);
        idle(2 * N + 2);

        // R6 R7 R9: fill with issue held off, then offer a beat that must be dropped
        mode_i = 1'b0;
        issue_en_i = 1'b0;
        for (int k = 0; k < N; k++) send(mk_row(40 + k), 0, 0);
        ld_valid_i = 1'b0;
        #0.1;
        check(ld_ready_o == 1'b0, "R7 ready low when full", ld_ready_o, 0);
        ld_valid_i = 1'b1;
        ld_data_i  = {N{16'h7777}};
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(arr_valid_o == '0, "R6 no issue when disabled", arr_valid_o, 0);
            check(ld_ready_o == 1'b0, "R7 ready stays low", ld_ready_o, 0);
        end
        ld_valid_i = 1'b0;
        issue_en_i = 1'b1;
        idle(2 * N + 2);

        // R6: partial sequential row never issues
        mode_i = 1'b1;
        send({{(N-1){16'h0BAD}}, 16'h6000}, 1, 0);
        send({{(N-1){16'h0BAD}}, 16'h6001}, 1, 0);
        ld_valid_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(arr_valid_o == '0, "R6 no issue on partial row", arr_valid_o, 0);
        end
        // R8: mode flips mid-row, rest of row must still load one sample per beat
        mode_i = 1'b0;
        for (int k = 2; k < N; k++) send({{(N-1){16'h0BAD}}, W'(16'h6000 + k)}, 1, 0);
        idle(2 * N + 2);

        // R8: once empty, parallel mode takes effect again
        send(mk_row(60), 0, 0);
        idle(2 * N + 2);

        for (int r = 0; r < N; r++) begin
            check(expq[r].size() == 0, "R9 all samples delivered", expq[r].size(), 0);
            check(skq[r].size() == 0, "R5 all rows matched", skq[r].size(), 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule